// File: doc/BRIEF.md
# Staged Link-Parameter Commit Controller

This block keeps the configuration of a serial-link transmitter in a bank of byte-wide staging registers and moves it into a set of active registers in one clock edge. A host drives a plain byte-wide write port (enable, address, data) and a combinational read port (address in, data out). Neither port has back-pressure: every cycle with the write enable high is one write taken at the next rising edge, and reads return on the same cycle.

An update is a two-step handshake. The host sets a start bit, which holds the transmitter and its PLL in reset. It then writes any of the fourteen parameter bytes and sets a complete bit. On that edge the staged values pass through a clamp that keeps lane count and converter resolution within the device's rated limits, and they are loaded into the active registers. Reset falls one clock later, and both control bits read back as zero from then on. The commit also checks that frames per multiframe times octets per frame stays inside the legal window. If it does not, a sticky error flag is raised and stays until the next start.

Count fields are stored as value minus one. The active fields and the two status flags leave the block as plain outputs.

Top module: `link_cfg_commit`

## Requirements
- R1: After reset, every active field output, `link_rst`, `config_error` and `clamp_flag` are 0, and every staging byte reads back 0.
- R2: A write of data with bit 0 set to address 0xDF starts an update. From the next edge `link_rst` is 1, a read of 0xDF returns 0x01, and both `config_error` and `clamp_flag` are 0.
- R3: Writes to 0xE0..0xED store the full byte into staging, whether or not an update is in progress. A read of that address returns the byte. Active outputs do not change until a commit.
- R4: A write of bit 0 set to 0xEE while an update is in progress commits. At that edge the active outputs take the (clamped) staged values, while `link_rst` stays 1 and 0xEE reads 0x01. One clock later `link_rst` is 0 and both 0xDF and 0xEE read 0x00.
- R5: Field layout, with count fields stored as value minus one. Device ID is 0xE0[7:0], bank ID 0xE1[3:0], lane ID 0xE2[4:0], scrambling enable 0xE3[7] (1 = on), lanes-minus-one 0xE3[4:0], octets-per-frame-minus-one 0xE4[7:0], frames-per-multiframe-minus-one 0xE5[4:0] (full 0..31 range) and resolution-minus-one 0xE6[4:0].
- R6: At commit, a staged lanes-minus-one above parameter MAX_LANES_M1 is replaced by MAX_LANES_M1, and `clamp_flag` is set.
- R7: At commit, a staged resolution-minus-one above parameter MAX_RES_M1 is replaced by MAX_RES_M1, and `clamp_flag` is set.
- R8: At commit, `config_error` is set when (F+1)*(K+1) is below 17 or above 1024, where F is 0xE4 and K is 0xE5[4:0]. It then holds through later cycles and parameter writes until the next start.
- R9: A write to 0xEE while no update is in progress does nothing: no reset, no change to active values or flags.
- R10: Reads of any address other than 0xDF and 0xE0..0xEE return 0x00.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| link_rst | output | 1 | Reset to transmitter and PLL |
| act_dev_id | output | 8 | Active device ID |
| act_bank_id | output | 4 | Active bank ID |
| act_lane_id | output | 5 | Active lane ID |
| act_scr_en | output | 1 | Active scrambling enable |
| act_lanes_m1 | output | 5 | Active lane count minus one |
| act_octets_m1 | output | 8 | Active octets per frame minus one |
| act_frames_m1 | output | 5 | Active frames per multiframe minus one |
| act_res_m1 | output | 5 | Active resolution minus one |
| config_error | output | 1 | Sticky multiframe sizing error |
| clamp_flag | output | 1 | Last commit was clamped |

## Verification
A wrong control state shows up at `link_rst` and at the 0xDF/0xEE read-back on the very next edge. Examples are a commit that is missed, reset released too early or held too long, or a stray complete write that is accepted. A wrong staging or clamp state only reaches the active outputs at the next commit, so every commit is followed at once by a compare of all active fields and both flags against values computed from the written bytes. Boundary products of 16, 17, 1024 and 1025 octets pin the window check to its exact edges.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef struct packed {
    logic [7:0] dev_id;
    logic [3:0] bank_id;
    logic [4:0] lane_id;
    logic       scr_en;
    logic [4:0] lanes_m1;
    logic [7:0] octets_m1;
    logic [4:0] frames_m1;
    logic [4:0] res_m1;
  } link_cfg_t;
endpackage

// File: rtl/lcc_stage_bank.sv
module lcc_stage_bank
  import lcc_pkg::*;
#(
  parameter int PARAM_BASE = 8'hE0,
  parameter int NUM_BYTES  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic       rd_hit,
  output logic [7:0] rd_byte,
  output link_cfg_t  staged_cfg
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam logic [7:0] BASE_A = 8'(PARAM_BASE);
  localparam logic [7:0] LAST_A = 8'(PARAM_BASE + NUM_BYTES - 1);

  logic [7:0] bank_q [NUM_BYTES];
  logic [7:0] rd_off;

  // R3: staging is written at any time; active copy is elsewhere
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) bank_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_BYTES; i++)
        if (wr_addr == 8'(PARAM_BASE + i)) bank_q[i] <= wr_data;
    end
  end

  assign rd_hit  = (rd_addr >= BASE_A) && (rd_addr <= LAST_A);
  assign rd_off  = rd_addr - BASE_A;
  assign rd_byte = rd_hit ? bank_q[rd_off[IDX_W-1:0]] : 8'h00;

  // R5: field positions decoded by the commit logic
  assign staged_cfg.dev_id    = bank_q[0];
  assign staged_cfg.bank_id   = bank_q[1][3:0];
  assign staged_cfg.lane_id   = bank_q[2][4:0];
  assign staged_cfg.scr_en    = bank_q[3][7];
  assign staged_cfg.lanes_m1  = bank_q[3][4:0];
  assign staged_cfg.octets_m1 = bank_q[4];
  assign staged_cfg.frames_m1 = bank_q[5][4:0];
  assign staged_cfg.res_m1    = bank_q[6][4:0];

  assert_stage_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BASE_A) |=> (staged_cfg.dev_id == $past(wr_data)));
endmodule

// File: rtl/lcc_commit_ctrl.sv
module lcc_commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic done_wr,
  output logic upd_busy,
  output logic commit_pend,
  output logic commit_fire,
  output logic link_rst
);
  assign commit_fire = done_wr && upd_busy && !start_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_busy    <= 1'b0;
      commit_pend <= 1'b0;
    end else if (start_wr) begin
      upd_busy    <= 1'b1;
      commit_pend <= 1'b0;
    end else if (commit_fire) begin
      upd_busy    <= 1'b0;
      commit_pend <= 1'b1;
    end else begin
      commit_pend <= 1'b0;
    end
  end

  assign link_rst = upd_busy | commit_pend;

  assert_start_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (upd_busy && link_rst));
  assert_commit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (link_rst && !upd_busy));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pend && !start_wr) |=> !link_rst);
  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && !upd_busy && !start_wr) |=> !commit_pend);
endmodule

// File: rtl/lcc_cfg_apply.sv
module lcc_cfg_apply
  import lcc_pkg::*;
#(
  parameter int MAX_LANES_M1 = 3,
  parameter int MAX_RES_M1   = 13,
  parameter int MIN_OPM      = 17,
  parameter int MAX_OPM      = 1024
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit_fire,
  input  logic      clear_flags,
  input  link_cfg_t staged_cfg,
  output link_cfg_t active_cfg,
  output logic      config_error,
  output logic      clamp_flag
);
  localparam int OPM_W = 14;

  logic [4:0]       lanes_c, res_c;
  logic             lane_ovr, res_ovr, opm_bad;
  logic [OPM_W-1:0] f_cnt, k_cnt, opm;
  link_cfg_t        next_cfg;

  generate
    if (MAX_LANES_M1 >= 31) begin : g_lane_pass
      assign lane_ovr = 1'b0;
      assign lanes_c  = staged_cfg.lanes_m1;
    end else begin : g_lane_clamp  // R6
      assign lane_ovr = staged_cfg.lanes_m1 > 5'(MAX_LANES_M1);
      assign lanes_c  = lane_ovr ? 5'(MAX_LANES_M1) : staged_cfg.lanes_m1;
    end
    if (MAX_RES_M1 >= 31) begin : g_res_pass
      assign res_ovr = 1'b0;
      assign res_c   = staged_cfg.res_m1;
    end else begin : g_res_clamp   // R7
      assign res_ovr = staged_cfg.res_m1 > 5'(MAX_RES_M1);
      assign res_c   = res_ovr ? 5'(MAX_RES_M1) : staged_cfg.res_m1;
    end
  endgenerate

  // R8: octets per multiframe window
  assign f_cnt   = OPM_W'(staged_cfg.octets_m1) + OPM_W'(1);
  assign k_cnt   = OPM_W'(staged_cfg.frames_m1) + OPM_W'(1);
  assign opm     = f_cnt * k_cnt;
  assign opm_bad = (opm < OPM_W'(MIN_OPM)) || (opm > OPM_W'(MAX_OPM));

  always_comb begin
    next_cfg          = staged_cfg;
    next_cfg.lanes_m1 = lanes_c;
    next_cfg.res_m1   = res_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_cfg <= '0;
    else if (commit_fire) active_cfg <= next_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      config_error <= 1'b0;
      clamp_flag   <= 1'b0;
    end else if (clear_flags) begin
      config_error <= 1'b0;
      clamp_flag   <= 1'b0;
    end else if (commit_fire) begin
      config_error <= opm_bad;
      clamp_flag   <= lane_ovr | res_ovr;
    end
  end

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(active_cfg));
  assert_lane_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_cfg.lanes_m1 <= 5'(MAX_LANES_M1));
  assert_res_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active_cfg.res_m1 <= 5'(MAX_RES_M1));
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(config_error) |-> $past(commit_fire));
endmodule

// File: rtl/link_cfg_commit.sv
module link_cfg_commit
  import lcc_pkg::*;
#(
  parameter int START_ADDR   = 8'hDF,
  parameter int PARAM_BASE   = 8'hE0,
  parameter int NUM_BYTES    = 14,
  parameter int DONE_ADDR    = 8'hEE,
  parameter int MAX_LANES_M1 = 3,
  parameter int MAX_RES_M1   = 13,
  parameter int MIN_OPM      = 17,
  parameter int MAX_OPM      = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       link_rst,
  output logic [7:0] act_dev_id,
  output logic [3:0] act_bank_id,
  output logic [4:0] act_lane_id,
  output logic       act_scr_en,
  output logic [4:0] act_lanes_m1,
  output logic [7:0] act_octets_m1,
  output logic [4:0] act_frames_m1,
  output logic [4:0] act_res_m1,
  output logic       config_error,
  output logic       clamp_flag
);
  localparam logic [7:0] START_A = 8'(START_ADDR);
  localparam logic [7:0] DONE_A  = 8'(DONE_ADDR);

  logic       start_wr, done_wr, upd_busy, commit_pend, commit_fire;
  logic       bank_hit;
  logic [7:0] bank_byte;
  link_cfg_t  staged_cfg, active_cfg;

  assign start_wr = wr_en && (wr_addr == START_A) && wr_data[0];
  assign done_wr  = wr_en && (wr_addr == DONE_A)  && wr_data[0];

  lcc_stage_bank #(.PARAM_BASE(PARAM_BASE), .NUM_BYTES(NUM_BYTES)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_hit(bank_hit),
    .rd_byte(bank_byte), .staged_cfg(staged_cfg)
  );

  lcc_commit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .done_wr(done_wr),
    .upd_busy(upd_busy), .commit_pend(commit_pend),
    .commit_fire(commit_fire), .link_rst(link_rst)
  );

  lcc_cfg_apply #(
    .MAX_LANES_M1(MAX_LANES_M1), .MAX_RES_M1(MAX_RES_M1),
    .MIN_OPM(MIN_OPM), .MAX_OPM(MAX_OPM)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire),
    .clear_flags(start_wr), .staged_cfg(staged_cfg),
    .active_cfg(active_cfg), .config_error(config_error),
    .clamp_flag(clamp_flag)
  );

  // R10: unmapped reads return zero; control bits read their live state
  always_comb begin
    if (rd_addr == START_A)      rd_data = {7'b0, upd_busy | commit_pend};
    else if (rd_addr == DONE_A)  rd_data = {7'b0, commit_pend};
    else if (bank_hit)           rd_data = bank_byte;
    else                         rd_data = 8'h00;
  end

  assign act_dev_id    = active_cfg.dev_id;
  assign act_bank_id   = active_cfg.bank_id;
  assign act_lane_id   = active_cfg.lane_id;
  assign act_scr_en    = active_cfg.scr_en;
  assign act_lanes_m1  = active_cfg.lanes_m1;
  assign act_octets_m1 = active_cfg.octets_m1;
  assign act_frames_m1 = active_cfg.frames_m1;
  assign act_res_m1    = active_cfg.res_m1;

  assert_done_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == DONE_A && wr_data[0] && rd_addr == START_A && rd_data[0])
      |=> link_rst);
endmodule

// File: tb/sim_link_cfg_commit.sv
module sim_link_cfg_commit;
  localparam int MAXL = 3, MAXR = 13;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00, rd_data;
  logic link_rst, act_scr_en, config_error, clamp_flag;
  logic [7:0] act_dev_id, act_octets_m1;
  logic [3:0] act_bank_id;
  logic [4:0] act_lane_id, act_lanes_m1, act_frames_m1, act_res_m1;

  int n_chk = 0, n_err = 0;
  logic [7:0] st [14];
  logic [7:0] e_dev, e_oct;
  logic [3:0] e_bank;
  logic [4:0] e_lid, e_lanes, e_frm, e_res;
  logic e_scr, e_err, e_clamp;

  link_cfg_commit u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    chk(tag, {24'b0, rd_data}, {24'b0, exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (a >= 8'hE0 && a <= 8'hED) st[a - 8'hE0] = d;
  endtask

  task automatic check_active(input string tag);
    chk({tag, " dev"},    {24'b0, act_dev_id},    {24'b0, e_dev});
    chk({tag, " bank"},   {28'b0, act_bank_id},   {28'b0, e_bank});
    chk({tag, " lid"},    {27'b0, act_lane_id},   {27'b0, e_lid});
    chk({tag, " scr"},    {31'b0, act_scr_en},    {31'b0, e_scr});
    chk({tag, " lanes"},  {27'b0, act_lanes_m1},  {27'b0, e_lanes});
    chk({tag, " oct"},    {24'b0, act_octets_m1}, {24'b0, e_oct});
    chk({tag, " frm"},    {27'b0, act_frames_m1}, {27'b0, e_frm});
    chk({tag, " res"},    {27'b0, act_res_m1},    {27'b0, e_res});
    chk({tag, " err"},    {31'b0, config_error},  {31'b0, e_err});
    chk({tag, " clamp"},  {31'b0, clamp_flag},    {31'b0, e_clamp});
  endtask

  function automatic logic opm_bad(input logic [7:0] f, input logic [4:0] k);
    int p = (int'(f) + 1) * (int'(k) + 1);
    return (p < 17) || (p > 1024);
  endfunction

  task automatic model_commit();
    logic [4:0] l = st[3][4:0], r = st[6][4:0];
    e_dev = st[0]; e_bank = st[1][3:0]; e_lid = st[2][4:0]; e_scr = st[3][7];
    e_oct = st[4]; e_frm = st[5][4:0];
    e_lanes = (l > 5'(MAXL)) ? 5'(MAXL) : l;
    e_res   = (r > 5'(MAXR)) ? 5'(MAXR) : r;
    e_clamp = (l > 5'(MAXL)) || (r > 5'(MAXR));
    e_err   = opm_bad(st[4], st[5][4:0]);
  endtask

  task automatic start_upd();
    wr(8'hDF, 8'h01);
    e_err = 1'b0; e_clamp = 1'b0;
    chk("R2 link_rst after start", {31'b0, link_rst}, 32'd1);
    rd(8'hDF, 8'h01, "R2 start bit readback");
    chk("R2 flags cleared", {30'b0, config_error, clamp_flag}, 32'd0);
  endtask

  task automatic commit(input string tag);
    wr(8'hEE, 8'h01);
    model_commit();
    check_active({"R4 ", tag});
    chk("R4 reset held at load", {31'b0, link_rst}, 32'd1);
    rd(8'hEE, 8'h01, "R4 done bit at load");
    @(negedge clk);
    chk("R4 reset released", {31'b0, link_rst}, 32'd0);
    rd(8'hDF, 8'h00, "R4 start bit cleared");
    rd(8'hEE, 8'h00, "R4 done bit cleared");
  endtask

  task automatic sizing(input logic [7:0] f, input logic [4:0] k, input logic exp, input string tag);
    start_upd();
    wr(8'hE4, f); wr(8'hE5, {3'b0, k});
    commit(tag);
    chk({"R8 ", tag}, {31'b0, config_error}, {31'b0, exp});
  endtask

  initial begin
    for (int i = 0; i < 14; i++) st[i] = 8'h00;
    e_dev = 0; e_oct = 0; e_bank = 0; e_lid = 0; e_lanes = 0; e_frm = 0;
    e_res = 0; e_scr = 0; e_err = 0; e_clamp = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_active("R1 reset");
    chk("R1 link_rst", {31'b0, link_rst}, 32'd0);
    for (int i = 0; i < 14; i++) rd(8'(8'hE0 + i), 8'h00, "R1 staging zero");

    // R9: complete while idle
    wr(8'hEE, 8'h01);
    chk("R9 no reset", {31'b0, link_rst}, 32'd0);
    rd(8'hEE, 8'h00, "R9 done bit stays 0");
    check_active("R9 idle done");

    // R3: staging writes outside an update, readback, no active change
    wr(8'hE0, 8'hA5); wr(8'hE3, 8'h82); wr(8'hE4, 8'h07); wr(8'hE5, 8'h03);
    wr(8'hE6, 8'h0B); wr(8'hED, 8'h5C);
    rd(8'hE0, 8'hA5, "R3 readback E0");
    rd(8'hED, 8'h5C, "R3 readback ED");
    check_active("R3 no active change");
    // R10 unmapped reads and a start write with bit 0 clear
    rd(8'h10, 8'h00, "R10 unmapped 10");
    rd(8'hEF, 8'h00, "R10 unmapped EF");
    wr(8'hDF, 8'h00);
    chk("R2 bit0 clear no start", {31'b0, link_rst}, 32'd0);

    // R5 layout via commit of bytes staged earlier
    start_upd();
    wr(8'hE1, 8'hF9); wr(8'hE2, 8'hF4);
    chk("R3 active frozen in update", {24'b0, act_dev_id}, 32'h0);
    commit("R5 layout");

    // R6/R7 clamps
    start_upd();
    wr(8'hE3, 8'h1F); wr(8'hE6, 8'h09);
    commit("R6 lane clamp");
    chk("R6 clamp_flag", {31'b0, clamp_flag}, 32'd1);
    start_upd();
    wr(8'hE3, 8'h03); wr(8'hE6, 8'h0E);
    commit("R7 res clamp");
    chk("R7 clamp_flag", {31'b0, clamp_flag}, 32'd1);
    chk("R7 lanes at limit kept", {27'b0, act_lanes_m1}, 32'd3);

    // R8 window edges
    sizing(8'd0,  5'd15, 1'b1, "opm 16");
    sizing(8'd16, 5'd0,  1'b0, "opm 17");
    sizing(8'd31, 5'd31, 1'b0, "opm 1024");
    sizing(8'd40, 5'd24, 1'b1, "opm 1025");
    // sticky until next start
    repeat (5) @(negedge clk);
    wr(8'hE4, 8'h10);
    wr(8'hEE, 8'h01);
    chk("R8 sticky after idle", {31'b0, config_error}, 32'd1);
    chk("R9 idle done keeps active", {24'b0, act_octets_m1}, 32'd40);
    start_upd();
    chk("R8 cleared by start", {31'b0, config_error}, 32'd0);
    commit("R8 recommit");

    // random staging and commits
    for (int n = 0; n < 60; n++) begin
      start_upd();
      for (int j = 0; j < 10; j++) begin
        logic [7:0] a = 8'(8'hE0 + ($urandom % 14));
        wr(a, 8'($urandom));
      end
      chk("R3 random frozen", {24'b0, act_dev_id}, {24'b0, e_dev});
      rd(8'hE4, st[4], "R3 random readback");
      commit("R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule